// File: doc/BRIEF.md
# Indirect Flash Transfer Sequencer

This block sequences register-started transfers for a quad-SPI flash controller in its indirect mode. Software loads a command: a direction, a data-phase setting, a start address, a byte count and a memory size code. The block then moves bytes one at a time between a single-byte holding register, which software sees as its data register, and a byte-level serializer that drives the flash pins. It advances the flash address after every byte and raises a sticky completion flag when the transfer ends. An interrupt line follows that flag when the interrupt enable is set.

The byte count can take one of three meanings. An ordinary value is an exact count. The all-ones value means "run until the last address of the configured memory". The all-ones value together with the largest size code means the transfer never finishes by itself, and the address rolls from the top of the 32-bit space back to zero. An abort request, or dropping the enable, ends any command at once.

Top module: `flash_xfer_seq`

## Requirements
- R1: After reset `busy`, `doneFlag`, `irq`, `serReq`, `hostWrReady` and `hostRdValid` are all 0.
- R2: A `cmdWrite` pulse starts a command only when the block is idle, `enable` is 1, `abortReq` is 0 and `cmdMode` is 00 (write) or 01 (read). `busy` rises on the next clock edge. Mode values 10 and 11, and any `cmdWrite` while busy, are ignored.
- R3: In a write command `hostWrReady` is 1 only while the data phase is active and the holding register is empty. `serReq` is raised only while it holds a byte, with `serIsWrite`=1, `serWdata` equal to that byte and `serAddr` equal to the start address plus the number of bytes already sent.
- R4: In a read command `serReq` is raised only while the holding register is empty, with `serIsWrite`=0. On an acknowledge, `serRdata` appears on `hostRdData` with `hostRdValid`=1 after the next edge. It stays there, and the transfer stalls, until `hostRdAck`.
- R5: With a count N that is neither 0 nor all ones, exactly N bytes move. `busy` falls and `doneFlag` rises on the edge that takes the Nth acknowledge.
- R6: With the count all ones and size code s < 31, the transfer ends after the byte at address 2^(s+1)-1.
- R7: With the count all ones and size code 31, the transfer never completes. The address steps from FFFF_FFFF to 0000_0000.
- R8: A command whose data-mode field is 00, or whose count is 0, has no data phase. `busy` is 1 for one cycle, then `doneFlag` rises, and `serReq` stays 0.
- R9: `abortReq`, or `enable`=0, while busy returns the block to idle on the next edge. It does not set `doneFlag` and it empties the holding register.
- R10: `doneFlag` stays set until a `flagClear` pulse. Completion wins over a clear in the same cycle. `irq` equals `doneFlag` AND `irqEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 cancels a running command |
| cmdWrite | input | 1 | Command register write strobe |
| cmdMode | input | 2 | 00 write, 01 read |
| cmdDataMode | input | 2 | 00 means no data phase |
| cmdAddr | input | ADDR_W | Start flash address |
| cmdLen | input | LEN_W | Byte count; all ones means undefined |
| sizeCode | input | SIZE_W | Memory size is 2^(code+1) bytes |
| irqEnable | input | 1 | Completion interrupt enable |
| abortReq | input | 1 | Abort request |
| flagClear | input | 1 | Clears the completion flag |
| hostWrValid | input | 1 | Software writes a byte to the data register |
| hostWrData | input | BYTE_W | Byte written by software |
| hostWrReady | output | 1 | Holding register can take a write byte |
| hostRdValid | output | 1 | Holding register has a read byte |
| hostRdData | output | BYTE_W | Read byte |
| hostRdAck | input | 1 | Software takes the read byte |
| serReq | output | 1 | Byte request to the serializer |
| serIsWrite | output | 1 | 1 for a write byte, 0 for a read byte |
| serAddr | output | ADDR_W | Flash address of the requested byte |
| serWdata | output | BYTE_W | Byte to send |
| serAck | input | 1 | Serializer finished the requested byte |
| serRdata | input | BYTE_W | Byte received, valid with serAck |
| busy | output | 1 | A command is in progress |
| doneFlag | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | Completion interrupt |

## Verification
Every result is due exactly one clock edge after the input that causes it. `busy` follows a `cmdWrite` by one edge. A byte acknowledged by the serializer changes `serAddr`, the holding register and, on the last byte, `busy` and `doneFlag` on that same edge. An abort or disable empties the block on the next edge. A no-data command shows one busy cycle before the flag. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge from the same inputs. One nanosecond after each falling edge it compares every output against the model, so each result is checked in the cycle it is due and in no other.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  typedef enum logic [1:0] {
    LEN_FIXED   = 2'd0,
    LEN_TO_END  = 2'd1,
    LEN_ENDLESS = 2'd2
  } lenKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch a new command
    logic flush;  // empty the holding register
    logic step;   // one byte completed on the serializer
  } seqStrobe_t;

  localparam logic [1:0] MODE_WRITE = 2'b00;
  localparam logic [1:0] MODE_READ  = 2'b01;
  localparam logic [1:0] DMODE_NONE = 2'b00;

endpackage

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
  import xfer_seq_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             abortReq,
  input  logic             cmdWrite,
  input  logic [1:0]       cmdMode,
  input  logic [1:0]       cmdDataMode,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             flagClear,
  input  logic             serReq,
  input  logic             serAck,
  input  logic             lastByte,
  output seqStrobe_t       strobe,
  output logic             dataActive,
  output logic             busy,
  output logic             doneFlag
);

  seqState_t state, stateNext;
  logic      kill;
  logic      modeOk;
  logic      noData;
  logic      start;
  logic      finish;
  logic      stepNow;

  assign kill    = abortReq | ~enable;
  assign modeOk  = (cmdMode == MODE_WRITE) | (cmdMode == MODE_READ);
  assign noData  = (cmdDataMode == DMODE_NONE) | (cmdLen == '0);
  assign start   = (state == ST_IDLE) & cmdWrite & modeOk & ~kill;
  assign stepNow = (state == ST_DATA) & serReq & serAck & ~kill;

  always_comb begin
    strobe.load  = start;
    strobe.flush = start | (kill & (state != ST_IDLE));
    strobe.step  = stepNow;
  end

  always_comb begin
    stateNext = state;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) stateNext = noData ? ST_FIN : ST_DATA;
      end
      ST_DATA: begin
        if (kill) begin
          stateNext = ST_IDLE;
        end else if (stepNow && lastByte) begin
          stateNext = ST_IDLE;
          finish    = 1'b1;
        end
      end
      ST_FIN: begin
        stateNext = ST_IDLE;
        finish    = ~kill;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  // completion flag: set has priority over software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (finish) begin
      doneFlag <= 1'b1;
    end else if (flagClear) begin
      doneFlag <= 1'b0;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign dataActive = (state == ST_DATA);

endmodule

// File: rtl/xfer_seq_dpath.sv
module xfer_seq_dpath
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int SIZE_W = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              dataActive,
  input  logic              cmdIsRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              hostWrValid,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              hostRdAck,
  input  logic [BYTE_W-1:0] serRdata,
  output logic              serReq,
  output logic              serIsWrite,
  output logic [ADDR_W-1:0] serAddr,
  output logic [BYTE_W-1:0] serWdata,
  output logic              hostWrReady,
  output logic              hostRdValid,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              lastByte
);

  localparam int SPAN_W    = ADDR_W + 1;
  localparam int FULL_CODE = ADDR_W - 1;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] endAddr;
  logic [LEN_W-1:0]  remaining;
  lenKind_t          kind;
  logic              isRead;
  logic              holdFull;
  logic [BYTE_W-1:0] holdData;

  logic              fullSpan;
  logic              lenAllOnes;
  logic [SPAN_W-1:0] spanBytes;
  logic [ADDR_W-1:0] endAddrNext;
  lenKind_t          kindNext;
  logic              pushOk;
  logic              popOk;

  // end-of-memory address from the size code: 2^(code+1) - 1
  assign fullSpan    = (32'(sizeCode) >= 32'(FULL_CODE));
  assign spanBytes   = SPAN_W'(1) << ({1'b0, sizeCode} + 1'b1);
  assign endAddrNext = fullSpan ? '1 : ADDR_W'(spanBytes - SPAN_W'(1));
  assign lenAllOnes  = &cmdLen;

  always_comb begin
    if (!lenAllOnes) begin
      kindNext = LEN_FIXED;
    end else if (fullSpan) begin
      kindNext = LEN_ENDLESS;
    end else begin
      kindNext = LEN_TO_END;
    end
  end

  // command registers, address and count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      endAddr   <= '0;
      remaining <= '0;
      kind      <= LEN_FIXED;
      isRead    <= 1'b0;
    end else if (strobe.load) begin
      curAddr   <= cmdAddr;
      endAddr   <= endAddrNext;
      remaining <= cmdLen;
      kind      <= kindNext;
      isRead    <= cmdIsRead;
    end else if (strobe.step) begin
      curAddr   <= curAddr + ADDR_W'(1);
      remaining <= remaining - LEN_W'(1);
    end
  end

  assign hostWrReady = dataActive & ~isRead & ~holdFull;
  assign hostRdValid = isRead & holdFull;
  assign pushOk      = hostWrValid & hostWrReady;
  assign popOk       = hostRdAck & hostRdValid;

  // single-byte holding register shared by both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else if (strobe.flush) begin
      holdFull <= 1'b0;
    end else if (strobe.step) begin
      holdFull <= isRead;
      if (isRead) holdData <= serRdata;
    end else if (pushOk) begin
      holdFull <= 1'b1;
      holdData <= hostWrData;
    end else if (popOk) begin
      holdFull <= 1'b0;
    end
  end

  always_comb begin
    unique case (kind)
      LEN_FIXED:  lastByte = (remaining == LEN_W'(1));
      LEN_TO_END: lastByte = (curAddr == endAddr);
      default:    lastByte = 1'b0;
    endcase
  end

  assign serReq     = dataActive & (isRead ? ~holdFull : holdFull);
  assign serIsWrite = ~isRead;
  assign serAddr    = curAddr;
  assign serWdata   = holdData;
  assign hostRdData = holdData;

endmodule

// File: rtl/flash_xfer_seq.sv
module flash_xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int SIZE_W = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cmdWrite,
  input  logic [1:0]        cmdMode,
  input  logic [1:0]        cmdDataMode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              irqEnable,
  input  logic              abortReq,
  input  logic              flagClear,
  input  logic              hostWrValid,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic              hostWrReady,
  output logic              hostRdValid,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic              hostRdAck,
  output logic              serReq,
  output logic              serIsWrite,
  output logic [ADDR_W-1:0] serAddr,
  output logic [BYTE_W-1:0] serWdata,
  input  logic              serAck,
  input  logic [BYTE_W-1:0] serRdata,
  output logic              busy,
  output logic              doneFlag,
  output logic              irq
);

  seqStrobe_t strobe;
  logic       dataActive;
  logic       lastByte;

  xfer_seq_ctrl #(
    .LEN_W(LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .abortReq   (abortReq),
    .cmdWrite   (cmdWrite),
    .cmdMode    (cmdMode),
    .cmdDataMode(cmdDataMode),
    .cmdLen     (cmdLen),
    .flagClear  (flagClear),
    .serReq     (serReq),
    .serAck     (serAck),
    .lastByte   (lastByte),
    .strobe     (strobe),
    .dataActive (dataActive),
    .busy       (busy),
    .doneFlag   (doneFlag)
  );

  xfer_seq_dpath #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .SIZE_W(SIZE_W),
    .BYTE_W(BYTE_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dataActive (dataActive),
    .cmdIsRead  (cmdMode[0]),
    .cmdAddr    (cmdAddr),
    .cmdLen     (cmdLen),
    .sizeCode   (sizeCode),
    .hostWrValid(hostWrValid),
    .hostWrData (hostWrData),
    .hostRdAck  (hostRdAck),
    .serRdata   (serRdata),
    .serReq     (serReq),
    .serIsWrite (serIsWrite),
    .serAddr    (serAddr),
    .serWdata   (serWdata),
    .hostWrReady(hostWrReady),
    .hostRdValid(hostRdValid),
    .hostRdData (hostRdData),
    .lastByte   (lastByte)
  );

  assign irq = doneFlag & irqEnable;

endmodule

// File: rtl/flash_xfer_seq_chk.sv
module flash_xfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int SIZE_W = 5,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              cmdWrite,
  input logic [1:0]        cmdMode,
  input logic [1:0]        cmdDataMode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [LEN_W-1:0]  cmdLen,
  input logic [SIZE_W-1:0] sizeCode,
  input logic              irqEnable,
  input logic              abortReq,
  input logic              flagClear,
  input logic              hostWrValid,
  input logic [BYTE_W-1:0] hostWrData,
  input logic              hostWrReady,
  input logic              hostRdValid,
  input logic [BYTE_W-1:0] hostRdData,
  input logic              hostRdAck,
  input logic              serReq,
  input logic              serIsWrite,
  input logic [ADDR_W-1:0] serAddr,
  input logic [BYTE_W-1:0] serWdata,
  input logic              serAck,
  input logic [BYTE_W-1:0] serRdata,
  input logic              busy,
  input logic              doneFlag,
  input logic              irq
);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serReq && !hostWrReady));

  a_r3_write_needs_byte: assert property (@(posedge clk) disable iff (!rstN)
    (serReq && serIsWrite) |-> !hostWrReady);

  a_r4_read_stall: assert property (@(posedge clk) disable iff (!rstN)
    (serReq && !serIsWrite) |-> !hostRdValid);

  a_r7_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (serReq && serAck && busy && enable && !abortReq)
      |=> (!serReq || serAddr == $past(serAddr) + ADDR_W'(1)));

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && busy) |=> (!busy && !serReq));

  a_r9_abort_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && busy && !doneFlag) |=> !doneFlag);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !flagClear) |=> doneFlag);

endmodule

bind flash_xfer_seq flash_xfer_seq_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W),
  .SIZE_W(SIZE_W),
  .BYTE_W(BYTE_W)
) u_chk (.*);

// File: tb/flash_xfer_seq_bench.sv
`timescale 1ns/1ps
module flash_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        cmdWrite = 1'b0;
  logic [1:0]  cmdMode = 2'b00;
  logic [1:0]  cmdDataMode = 2'b00;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdLen = '0;
  logic [4:0]  sizeCode = '0;
  logic        irqEnable = 1'b0;
  logic        abortReq = 1'b0;
  logic        flagClear = 1'b0;
  logic        hostWrValid = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic        hostWrReady;
  logic        hostRdValid;
  logic [7:0]  hostRdData;
  logic        hostRdAck = 1'b0;
  logic        serReq;
  logic        serIsWrite;
  logic [31:0] serAddr;
  logic [7:0]  serWdata;
  logic        serAck = 1'b0;
  logic [7:0]  serRdata;
  logic        busy;
  logic        doneFlag;
  logic        irq;

  always #4 clk = ~clk;

  flash_xfer_seq u_flash_xfer_seq (.*);

  function automatic logic [7:0] flashByte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign serRdata = flashByte(serAddr);

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R1";

  // stimulus generator knobs
  bit        ackRandom = 1'b0;
  bit        wrEn = 1'b0;
  bit        rdEn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int          mState = 0;       // 0 idle, 1 data, 2 no-data finish
  logic [31:0] mAddr = '0;
  logic [31:0] mRem = '0;
  logic [31:0] mEnd = '0;
  int          mKind = 0;        // 0 fixed, 1 to end, 2 endless
  bit          mRead = 1'b0;
  bit          mFull = 1'b0;
  bit          mDone = 1'b0;
  logic [7:0]  mHold = '0;
  int          stepCnt = 0;
  int          wrByte = 0;

  function automatic bit expSerReq();
    return (mState == 1) && (mRead ? !mFull : mFull);
  endfunction

  always @(posedge clk) begin
    bit kill, sreq, step, push, pop, start, last;
    if (!rstN) begin
      mState = 0; mRead = 0; mFull = 0; mDone = 0;
    end else begin
      kill  = abortReq || !enable;
      sreq  = expSerReq();
      step  = sreq && serAck && !kill;
      push  = hostWrValid && (mState == 1) && !mRead && !mFull;
      pop   = hostRdAck && mRead && mFull;
      start = (mState == 0) && cmdWrite && !kill && (cmdMode[1] == 1'b0);
      last  = (mKind == 0) ? (mRem == 32'd1) : (mKind == 1) ? (mAddr == mEnd) : 1'b0;
      if (flagClear) mDone = 0;
      if (mState != 0 && kill) begin
        mState = 0; mFull = 0;
      end else if (start) begin
        mAddr = cmdAddr; mRem = cmdLen; mRead = cmdMode[0]; mFull = 0;
        mEnd  = (sizeCode == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (sizeCode + 1)) - 32'd1);
        if (cmdLen != 32'hFFFF_FFFF) mKind = 0;
        else if (sizeCode == 5'd31) mKind = 2;
        else mKind = 1;
        mState = (cmdDataMode == 2'b00 || cmdLen == 0) ? 2 : 1;
      end else if (mState == 2) begin
        mState = 0; mDone = 1;
      end else if (step) begin
        stepCnt++;
        if (mRead) begin mFull = 1; mHold = flashByte(mAddr); end
        else mFull = 0;
        mAddr = mAddr + 1;
        mRem  = mRem - 1;
        if (last) begin mState = 0; mDone = 1; end
      end else if (push) begin
        mFull = 1; mHold = hostWrData; wrByte++;
      end else if (pop) begin
        mFull = 0;
      end
    end
  end

  // serializer and software-side generator
  always @(negedge clk) begin
    lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    serAck      <= ackRandom ? lfsr[0] : 1'b1;
    hostWrValid <= wrEn && lfsr[1];
    hostWrData  <= 8'h30 + 8'(wrByte);
    hostRdAck   <= rdEn && lfsr[2];
  end

  task automatic cmp(string sig, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL [%s] %s act=%h exp=%h t=%0t", curReq, sig, act, exp, $time);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL [%s] directed act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      #1;
      cmp("busy", 32'(busy), 32'(mState != 0));
      cmp("doneFlag", 32'(doneFlag), 32'(mDone));
      cmp("irq", 32'(irq), 32'(mDone && irqEnable));
      cmp("serReq", 32'(serReq), 32'(expSerReq()));
      cmp("hostWrReady", 32'(hostWrReady), 32'((mState == 1) && !mRead && !mFull));
      cmp("hostRdValid", 32'(hostRdValid), 32'(mRead && mFull));
      if (expSerReq()) begin
        cmp("serAddr", serAddr, mAddr);
        cmp("serIsWrite", 32'(serIsWrite), 32'(!mRead));
        if (!mRead) cmp("serWdata", 32'(serWdata), 32'(mHold));
      end
      if (mRead && mFull) cmp("hostRdData", 32'(hostRdData), 32'(mHold));
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL [watchdog] act=timeout exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic issue(logic [1:0] md, logic [1:0] dm, logic [31:0] a,
                       logic [31:0] n, logic [4:0] sz);
    @(negedge clk);
    cmdMode = md; cmdDataMode = dm; cmdAddr = a; cmdLen = n; sizeCode = sz;
    cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mState != 0) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", 32'(busy), 0);
    chk("R1", 32'(doneFlag), 0);
    chk("R1", 32'(serReq), 0);
    chk("R1", 32'(hostRdValid), 0);
    rstN = 1'b1;
    irqEnable = 1'b1;

    // R3 / R5: fixed-count write with irregular software and serializer
    curReq = "R3"; ackRandom = 1; wrEn = 1; stepCnt = 0; wrByte = 0;
    issue(2'b00, 2'b11, 32'h0000_0100, 32'd5, 5'd20);
    waitIdle();
    chk("R5", stepCnt, 5);
    chk("R3", wrByte, 5);
    chk("R5", 32'(doneFlag), 1);
    chk("R10", 32'(irq), 1);
    wrEn = 0;
    repeat (3) @(negedge clk);
    chk("R10", 32'(doneFlag), 1);
    irqEnable = 0;
    @(negedge clk);
    chk("R10", 32'(irq), 0);
    clearFlag();
    chk("R10", 32'(doneFlag), 0);
    irqEnable = 1;

    // R4: read with software stalling
    curReq = "R4"; stepCnt = 0; rdEn = 0; ackRandom = 0;
    issue(2'b01, 2'b11, 32'h0000_02F0, 32'd4, 5'd20);
    repeat (8) @(negedge clk);
    chk("R4", 32'(hostRdValid), 1);
    chk("R4", 32'(serReq), 0);
    chk("R4", stepCnt, 1);
    rdEn = 1;
    waitIdle();
    chk("R4", stepCnt, 4);
    repeat (10) @(negedge clk);
    rdEn = 0;
    clearFlag();

    // R2: illegal mode ignored, command while busy ignored
    curReq = "R2";
    issue(2'b10, 2'b11, 32'h10, 32'd2, 5'd4);
    @(negedge clk);
    chk("R2", 32'(busy), 0);
    issue(2'b11, 2'b11, 32'h10, 32'd2, 5'd4);
    @(negedge clk);
    chk("R2", 32'(busy), 0);
    stepCnt = 0; wrEn = 0;
    issue(2'b00, 2'b11, 32'h40, 32'd3, 5'd10);
    chk("R2", 32'(busy), 1);
    issue(2'b01, 2'b11, 32'h80, 32'd9, 5'd10);
    @(negedge clk);
    chk("R2", 32'(hostWrReady), 1);
    wrEn = 1;
    waitIdle();
    chk("R2", stepCnt, 3);
    wrEn = 0;
    clearFlag();

    // R6: undefined count stops at end of a 16-byte memory
    curReq = "R6"; stepCnt = 0; rdEn = 1; ackRandom = 1;
    issue(2'b01, 2'b01, 32'h0000_000C, 32'hFFFF_FFFF, 5'd3);
    waitIdle();
    chk("R6", stepCnt, 4);
    chk("R6", 32'(doneFlag), 1);
    repeat (10) @(negedge clk);
    clearFlag();

    // R7: endless stream wraps the address, then abort
    curReq = "R7"; stepCnt = 0; ackRandom = 0; rdEn = 1;
    issue(2'b01, 2'b10, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 5'd31);
    while (!(serReq && stepCnt == 2)) @(negedge clk);
    chk("R7", serAddr, 32'h0000_0000);
    while (stepCnt < 6) @(negedge clk);
    chk("R7", 32'(busy), 1);
    chk("R7", 32'(doneFlag), 0);
    curReq = "R9";
    abortReq = 1;
    @(negedge clk);
    abortReq = 0;
    chk("R9", 32'(busy), 0);
    chk("R9", 32'(doneFlag), 0);
    chk("R9", 32'(hostRdValid), 0);
    rdEn = 0;

    // R8: no data phase, by data mode and by zero count
    curReq = "R8";
    issue(2'b00, 2'b00, 32'h1234, 32'd8, 5'd20);
    chk("R8", 32'(busy), 1);
    chk("R8", 32'(serReq), 0);
    @(negedge clk);
    chk("R8", 32'(busy), 0);
    chk("R8", 32'(doneFlag), 1);
    clearFlag();
    issue(2'b01, 2'b11, 32'h1234, 32'd0, 5'd20);
    chk("R8", 32'(hostRdValid), 0);
    @(negedge clk);
    chk("R8", 32'(doneFlag), 1);
    clearFlag();

    // R9: abort mid-write, disable mid-read
    curReq = "R9"; stepCnt = 0; wrEn = 1; ackRandom = 1;
    issue(2'b00, 2'b11, 32'h500, 32'd10, 5'd20);
    while (stepCnt < 3) @(negedge clk);
    abortReq = 1;
    @(negedge clk);
    abortReq = 0;
    chk("R9", 32'(busy), 0);
    chk("R9", 32'(hostWrReady), 0);
    chk("R9", 32'(doneFlag), 0);
    wrEn = 0; stepCnt = 0; ackRandom = 0;
    issue(2'b01, 2'b11, 32'h600, 32'd10, 5'd20);
    while (stepCnt < 1) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk("R9", 32'(busy), 0);
    chk("R9", 32'(hostRdValid), 0);
    issue(2'b01, 2'b11, 32'h600, 32'd10, 5'd20);
    chk("R9", 32'(busy), 0);
    enable = 1;

    // R10: completion wins over a clear in the same cycle
    curReq = "R10";
    @(negedge clk);
    cmdMode = 2'b00; cmdDataMode = 2'b00; cmdLen = 32'd1; cmdWrite = 1;
    @(negedge clk);
    cmdWrite = 0; flagClear = 1;
    @(negedge clk);
    flagClear = 0;
    chk("R10", 32'(doneFlag), 1);
    chk("R10", 32'(irq), 1);
    clearFlag();

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule